// File: doc/BRIEF.md
# Two-Wire Slave Interrupt Status and Enable Registers

This block holds the interrupt state of a two-wire slave peripheral. Twelve event lines from the bus engine and the data FIFOs feed a status register. Ten of the lines are single-cycle pulses, and each one sets a sticky status bit. The other two report live FIFO conditions (receive FIFO full, transmit FIFO empty). Their status bits follow the condition and clear on their own once it ends. A mask register enables each source. A single interrupt line is raised while at least one status bit is set and its enable bit is set.

The CPU reaches both registers through a small register port. A select input picks the status register or the mask register, the read data is presented combinationally, and a write strobe updates the selected register. Reading never alters the status. A sticky bit is cleared only by writing a zero to its position, and writing a one to it is ignored. When the hardware set and the CPU clear hit the same bit in one cycle, the set takes effect.

Status bit positions: 0 start, 1 repeated start with write direction, 2 repeated start with read direction, 3 stop, 4 timeout, 5 receive byte, 6 receive command, 7 receive buffer empty, 8 receive FIFO full (level), 9 transmit byte, 10 transmit buffer full, 11 transmit FIFO empty (level). Bits 15..12 of both registers are unused.

Top module: `twi_irq_ctrl`

## Requirements
- R1: After reset, every status bit and every mask bit reads 0 and irq_o is 0.
- R2: irq_o is 1 exactly when, for some bit position 0..11, both the status bit and the mask bit are 1. It reflects the register contents in the same cycle.
- R3: An event pulse on any edge source (evt_i bits 0..7, 9 and 10) sets its status bit on the next clock edge. The bit stays set while no clear is applied.
- R4: A status write (cpu_sel_i=0, cpu_wr_i=1) with a 0 in an edge bit position clears that bit on the next edge, provided the same source has no event in that cycle.
- R5: A status write with a 1 in an edge bit position leaves that bit unchanged.
- R6: Status bits 8 and 11 are level bits. On every clock edge each one takes the current value of its evt_i line.
- R7: When an edge event and a status write of 0 hit the same bit in one cycle, the bit ends up set.
- R8: Reading either register (cpu_wr_i=0) changes neither register, however often it is read.
- R9: A mask write (cpu_sel_i=1, cpu_wr_i=1) loads cpu_wdata_i[11:0] into the mask on the next edge. The mask reads back unchanged until the next mask write.
- R10: Bits 15..12 of the read data are always 0, even after writes of 1 to those positions.
- R11: CPU status writes of either 0 or 1 have no effect on the level bits 8 and 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 12 | Event lines: pulses for edge bits, live conditions for bits 8 and 11 |
| cpu_sel_i | input | 1 | Register select: 0 status, 1 mask |
| cpu_wr_i | input | 1 | Write strobe for the selected register |
| cpu_wdata_i | input | 16 | Write data |
| cpu_rdata_o | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: the hardware set of a sticky bit from an event pulse, and the CPU clear of that bit from a status write of zero. The bench provokes this for every edge source by driving that source's pulse in the cycle of an all-zero status write. It then expects the bit to read back as one while every other sticky bit reads zero. A second collision, a CPU write against a live level condition, is made by writing zeros and ones while the FIFO lines are held high and low. Each result is judged against a register model kept in the bench.

// File: rtl/twi_irq_pkg.sv
package twi_irq_pkg;
  localparam int SRC_N = 12;
  localparam int REG_W = 16;

  localparam int B_START     = 0;
  localparam int B_RSTART_WR = 1;
  localparam int B_RSTART_RD = 2;
  localparam int B_STOP      = 3;
  localparam int B_TIMEOUT   = 4;
  localparam int B_RX_BYTE   = 5;
  localparam int B_RX_CMD    = 6;
  localparam int B_RX_EMPTY  = 7;
  localparam int B_RX_FULL   = 8;
  localparam int B_TX_BYTE   = 9;
  localparam int B_TX_FULL   = 10;
  localparam int B_TX_EMPTY  = 11;

  localparam logic [SRC_N-1:0] LEVEL_SRC_DEF =
    SRC_N'((1 << B_RX_FULL) | (1 << B_TX_EMPTY));

  typedef enum logic {SEL_STAT = 1'b0, SEL_MASK = 1'b1} reg_sel_e;

  // next value of a sticky bit: a set outranks a clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic irq_any(input logic [SRC_N-1:0] stat, input logic [SRC_N-1:0] mask);
    return |(stat & mask);
  endfunction
endpackage

// File: rtl/twi_irq_bit.sv
module twi_irq_bit #(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic q_o
);
  import twi_irq_pkg::*;

  logic q_d;
  assign q_d = IS_LEVEL ? evt_i : sticky_next(q_o, evt_i, clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  generate
    if (IS_LEVEL) begin : g_lvl_chk
      p_level_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> q_o == $past(evt_i));
      p_level_ignores_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !q_o);
    end else begin : g_edge_chk
      p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> q_o);
      p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !q_o);
      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !evt_i) |=> q_o == $past(q_o));
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i) |=> q_o);
    end
  endgenerate
endmodule

// File: rtl/twi_irq_mask.sv
module twi_irq_mask #(
  parameter int SRC_N = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SRC_N-1:0] wdata_i,
  output logic [SRC_N-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '0;
    else if (wr_i) mask_o <= wdata_i;
  end

  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> mask_o == $past(wdata_i));
  p_mask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/twi_irq_rdmux.sv
module twi_irq_rdmux #(
  parameter int SRC_N = 12,
  parameter int REG_W = 16
) (
  input  logic             sel_i,
  input  logic [SRC_N-1:0] stat_i,
  input  logic [SRC_N-1:0] mask_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  import twi_irq_pkg::*;

  localparam int PAD_W = REG_W - SRC_N;

  always_comb begin
    rdata_o = '0;
    rdata_o[SRC_N-1:0] = (sel_i == SEL_MASK) ? mask_i : stat_i;
  end

  assign irq_o = irq_any(stat_i, mask_i);

  always_comb begin
    a_pad_zero_r10: assert (rdata_o[REG_W-1:REG_W-PAD_W] == '0);
  end
endmodule

// File: rtl/twi_irq_ctrl.sv
module twi_irq_ctrl #(
  parameter int                          SRC_N     = twi_irq_pkg::SRC_N,
  parameter int                          REG_W     = twi_irq_pkg::REG_W,
  parameter logic [twi_irq_pkg::SRC_N-1:0] LEVEL_SRC = twi_irq_pkg::LEVEL_SRC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt_i,
  input  logic             cpu_sel_i,
  input  logic             cpu_wr_i,
  input  logic [REG_W-1:0] cpu_wdata_i,
  output logic [REG_W-1:0] cpu_rdata_o,
  output logic             irq_o
);
  import twi_irq_pkg::*;

  // named internal events for the checks
  logic             wr_stat;
  logic             wr_mask;
  logic [SRC_N-1:0] clr_vec;
  logic [SRC_N-1:0] stat_q;
  logic [SRC_N-1:0] mask_q;
  logic             unused_wdata_hi;

  assign wr_stat = cpu_wr_i && (cpu_sel_i == SEL_STAT);
  assign wr_mask = cpu_wr_i && (cpu_sel_i == SEL_MASK);
  assign clr_vec = wr_stat ? ~cpu_wdata_i[SRC_N-1:0] : '0;
  assign unused_wdata_hi = ^cpu_wdata_i[REG_W-1:SRC_N];

  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    twi_irq_bit #(.IS_LEVEL(LEVEL_SRC[i])) u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_i[i]),
      .clr_i (clr_vec[i]),
      .q_o   (stat_q[i])
    );
  end

  twi_irq_mask #(.SRC_N(SRC_N)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_mask),
    .wdata_i (cpu_wdata_i[SRC_N-1:0]),
    .mask_o  (mask_q)
  );

  twi_irq_rdmux #(.SRC_N(SRC_N), .REG_W(REG_W)) u_rdmux (
    .sel_i   (cpu_sel_i),
    .stat_i  (stat_q),
    .mask_i  (mask_q),
    .rdata_o (cpu_rdata_o),
    .irq_o   (irq_o)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (stat_q == '0 && mask_q == '0));
  p_irq_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) != '0) |-> irq_o);
  p_irq_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) == '0) |-> !irq_o);
  p_read_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr_i && ((evt_i & ~LEVEL_SRC) == '0) && ((stat_q & LEVEL_SRC) == (evt_i & LEVEL_SRC)))
    |=> ($stable(stat_q) && $stable(mask_q)));
endmodule

// File: tb/twi_irq_ctrl_tb.sv
module twi_irq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam logic [11:0] LVL = 12'h900;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt = '0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  logic [11:0] m_stat = '0;
  logic [11:0] m_mask = '0;
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  twi_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cpu_sel_i(sel),
    .cpu_wr_i(wr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .irq_o(irq)
  );

  // drive one cycle of stimulus, advance the model, return at the falling edge
  task automatic step(input logic [11:0] e, input logic w, input logic s, input logic [15:0] d);
    logic [11:0] clr;
    evt = e; wr = w; sel = s; wdata = d;
    @(posedge clk);
    clr = (w && !s) ? ~d[11:0] : 12'h000;
    m_stat = (LVL & e) | (~LVL & ((e & ~LVL) | (m_stat & ~clr)));
    if (w && s) m_mask = d[11:0];
    @(negedge clk);
    wr = 1'b0; evt = e & LVL;
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    sel = 1'b0; #1;
    chk(tag, "status", rdata, {4'h0, m_stat});
    sel = 1'b1; #1;
    chk(tag, "mask", rdata, {4'h0, m_mask});
    chk("R2", "irq", {15'h0, irq}, {15'h0, |(m_stat & m_mask)});
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [15:0] snap;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // edge sources: set, ignore ones, enable, collision, clear
    for (int i = 0; i < 12; i++) begin
      if (!LVL[i]) begin
        step(12'(1 << i), 1'b0, 1'b0, 16'h0);      check_all("R3");
        step(12'h0, 1'b1, 1'b0, 16'hFFFF);         check_all("R5");
        step(12'h0, 1'b1, 1'b1, 16'(1 << i));      check_all("R9");
        step(12'h0, 1'b1, 1'b0, 16'h0);            check_all("R4");
        step(12'(1 << i), 1'b1, 1'b0, 16'h0);      check_all("R7");
        step(12'h0, 1'b1, 1'b0, ~16'(1 << i));     check_all("R5");
        step(12'h0, 1'b1, 1'b0, 16'h0);            check_all("R4");
      end
    end

    // level sources: follow the line, ignore CPU writes
    for (int i = 0; i < 12; i++) begin
      if (LVL[i]) begin
        step(12'(1 << i), 1'b1, 1'b1, 16'(1 << i)); check_all("R6");
        step(12'(1 << i), 1'b1, 1'b0, 16'h0);       check_all("R11");
        step(12'(1 << i), 1'b0, 1'b0, 16'h0);       check_all("R6");
        step(12'h0, 1'b1, 1'b0, 16'hFFFF);          check_all("R11");
        step(12'h0, 1'b0, 1'b0, 16'h0);             check_all("R6");
      end
    end

    // upper bits
    step(12'h0, 1'b1, 1'b1, 16'hF000);  check_all("R10");
    step(12'h0, 1'b1, 1'b0, 16'hF000);  check_all("R10");

    // mask sweep against a full status
    step(12'hFFF, 1'b0, 1'b0, 16'h0);
    for (int i = 0; i < 12; i++) begin
      step(LVL, 1'b1, 1'b1, 16'(1 << i)); check_all("R2");
    end

    // repeated reads leave everything alone
    step(12'h0FF, 1'b1, 1'b1, 16'h0A5A);
    evt = 12'h0;
    sel = 1'b0; #1; snap = rdata;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      sel = 1'b0; #1; chk("R8", "status reread", rdata, snap);
      sel = 1'b1; #1; chk("R8", "mask reread", rdata, 16'h0A5A);
    end

    // pseudo-random walk
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[11:0] & {6'h3F, lfsr[15:10]}, lfsr[3] ^ lfsr[9], lfsr[14], {lfsr[7:0], lfsr[15:8]});
      check_all("R7");
    end

    // reset again mid-run
    rst_n = 1'b0; m_stat = '0; m_mask = '0; evt = '0;
    @(negedge clk);
    check_all("R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule